// File: doc/BRIEF.md
# Supervisory reset timeout sequencer

This block produces the system reset for a processor from two conditions. One is a digital undervoltage flag that an external threshold comparator drives. The other is an active-low manual reset request from a button or from other logic. While either condition is present, reset is asserted. Once both conditions have cleared, reset stays asserted for a fixed timeout. Any new condition that arrives during that timeout clears the timer to zero, and the full timeout starts again only after the conditions clear.

Both raw inputs pass through a two-stage synchronizer and then a stability filter. A filter accepts a condition only after the synchronized input has been continuously active for a set number of cycles. It drops the condition on the first inactive sample, so recovery starts the timeout at once. This filter rejects short dips on the undervoltage flag and glitches on the manual input. Reset is presented in three forms: an active-low level, its exact inverse, and a pull-low enable for a shared open-drain reset line. A two-bit cause field reports what held the current reset.

The timeout is given in clock cycles, together with the clock frequency it assumes. Elaboration stops with an error if the timeout falls outside 100 ms to 280 ms at that frequency.

Top module: `supv_reset_seq`

## Requirements
- R1: While `arstN` is low, `resetN` is 0, `resetHi` is 1, `resetPullLow` is 1 and `holdCause` is 2'b01. After `arstN` rises, with both inputs inactive, `resetN` rises on the TIMEOUT_CYCLES-th rising clock edge.
- R2: If `uvRaw` is held high for at least UV_FILTER_CYCLES cycles, `resetN` goes low after exactly UV_FILTER_CYCLES+3 rising edges, counted from the first edge that samples it high. In the same cycle, bit 0 of `holdCause` is set.
- R3: A high pulse on `uvRaw` shorter than UV_FILTER_CYCLES cycles does not assert reset. It also does not restart a timeout that is already running.
- R4: Reset rises exactly TIMEOUT_CYCLES+4 rising edges after the last raw condition clears. The first of those edges is the one that samples the inputs inactive.
- R5: A condition accepted while the timeout is running clears the timer. Reset then stays low until TIMEOUT_CYCLES+4 edges after that new condition clears.
- R6: If `manualN` is held low for at least MR_FILTER_CYCLES cycles, `resetN` goes low after exactly MR_FILTER_CYCLES+3 edges and stays low for as long as `manualN` is low.
- R7: A low pulse on `manualN` shorter than MR_FILTER_CYCLES cycles does not assert reset.
- R8: `resetHi` is always the logical inverse of `resetN`.
- R9: `resetPullLow` is 1 exactly when reset is asserted, so the shared line is only pulled low or released.
- R10: In `holdCause`, bit 0 means undervoltage and bit 1 means manual request. The bits accumulate over one hold, so 2'b11 means both conditions occurred. The field is 2'b00 whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| arstN | input | 1 | Asynchronous power-on reset, active low |
| uvRaw | input | 1 | Undervoltage flag from the comparator, active high, asynchronous |
| manualN | input | 1 | Manual reset request, active low, asynchronous |
| resetN | output | 1 | System reset, active low |
| resetHi | output | 1 | System reset, active high |
| resetPullLow | output | 1 | Pull-down enable for an open-drain reset line |
| holdCause | output | 2 | Cause of the current hold: bit 0 undervoltage, bit 1 manual |

## Verification
The hardest case to reach is a second condition that arrives in the middle of a running timeout. It must restart the count without releasing reset early, and it must leave both cause bits set. The bench reaches this case by holding an undervoltage pulse, releasing it, and then pressing the manual input hundreds of cycles into the count. It then checks the old release edge and the new one. The filter boundaries are hit exactly, with pulses of the threshold width and one cycle shorter. Every input edge is driven on a falling clock edge, so the width seen after the synchronizer equals the driven width.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Source indices; also the bit positions of the cause field.
  localparam int SRC_UV  = 0;
  localparam int SRC_MAN = 1;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,   // a condition is present, timer held at zero
    ST_TIME = 2'd1,   // conditions clear, timer running
    ST_DONE = 2'd2    // timeout elapsed, reset released
  } seqState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic causeClr;
  } seqStrobes_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/supv_filter.sv
// Accepts an active-high condition after STABLE_CYCLES consecutive active
// samples; drops it on the first inactive sample.
module supv_filter #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic arstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int RunW = $clog2(STABLE_CYCLES + 1);
  localparam logic [RunW-1:0] RunLast = RunW'(STABLE_CYCLES - 1);

  logic [RunW-1:0] run;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      run     <= '0;
      filtOut <= 1'b0;
    end else if (!rawIn) begin
      run     <= '0;
      filtOut <= 1'b0;
    end else if (run == RunLast) begin
      filtOut <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int TIMEOUT_CYCLES   = 50_000_000,
  parameter int UV_FILTER_CYCLES = 2500,
  parameter int MR_FILTER_CYCLES = 25,
  parameter int CNT_W            = 26
) (
  input  logic               clk,
  input  logic               arstN,
  input  logic               uvRaw,
  input  logic               manualN,
  input  seqStrobes_t        strb,
  output logic [NUM_SRC-1:0] reqSync,
  output logic [NUM_SRC-1:0] reqFilt,
  output logic               timeoutHit,
  output logic [CNT_W-1:0]   countVal,
  output logic [NUM_SRC-1:0] holdCause
);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [NUM_SRC-1:0] rawReq;
  assign rawReq[SRC_UV]  = uvRaw;
  assign rawReq[SRC_MAN] = ~manualN;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gen_src
    localparam int Stable = (i == SRC_UV) ? UV_FILTER_CYCLES : MR_FILTER_CYCLES;

    supv_sync #(.STAGES(2)) uSync (
      .clk  (clk),
      .arstN(arstN),
      .d    (rawReq[i]),
      .q    (reqSync[i])
    );

    supv_filter #(.STABLE_CYCLES(Stable)) uFilt (
      .clk    (clk),
      .arstN  (arstN),
      .rawIn  (reqSync[i]),
      .filtOut(reqFilt[i])
    );
  end

  // Timeout counter; power-on starts it from zero.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)           countVal <= '0;
    else if (strb.cntClr) countVal <= '0;
    else if (strb.cntEn)  countVal <= countVal + 1'b1;
  end

  assign timeoutHit = (countVal == CntLast);

  // Cause bits accumulate over one hold; power-on counts as undervoltage.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             holdCause <= NUM_SRC'(1) << SRC_UV;
    else if (strb.causeClr) holdCause <= '0;
    else                    holdCause <= holdCause | reqFilt;
  end
endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        arstN,
  input  logic        eventAny,
  input  logic        timeoutHit,
  output seqStrobes_t strb,
  output logic        holdActive
);
  seqState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    if (eventAny) begin
      nextState   = ST_HOLD;
      strb.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_HOLD: begin
          nextState   = ST_TIME;
          strb.cntClr = 1'b1;
        end
        ST_TIME: begin
          strb.cntEn = 1'b1;
          if (timeoutHit) begin
            nextState     = ST_DONE;
            strb.causeClr = 1'b1;
          end
        end
        default: nextState = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      state      <= ST_TIME;
      holdActive <= 1'b1;
    end else begin
      state      <= nextState;
      holdActive <= (nextState != ST_DONE);
    end
  end
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int CLK_HZ           = 250_000_000,
  parameter int TIMEOUT_CYCLES   = 50_000_000,
  parameter int UV_FILTER_CYCLES = 2500,
  parameter int MR_FILTER_CYCLES = 25
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       uvRaw,
  input  logic       manualN,
  output logic       resetN,
  output logic       resetHi,
  output logic       resetPullLow,
  output logic [1:0] holdCause
);
  localparam int CntW = $clog2(TIMEOUT_CYCLES + 1);
  localparam longint MinTimeout = longint'(CLK_HZ) / 10;
  localparam longint MaxTimeout = (longint'(CLK_HZ) * 28) / 100;

  if (longint'(TIMEOUT_CYCLES) < MinTimeout || longint'(TIMEOUT_CYCLES) > MaxTimeout) begin : gen_bad_timeout
    $error("timeout outside 100..280 ms at the given clock frequency");
  end
  if (UV_FILTER_CYCLES < 1 || MR_FILTER_CYCLES < 1) begin : gen_bad_filter
    $error("filter lengths must be at least one cycle");
  end

  seqStrobes_t        strb;
  logic [NUM_SRC-1:0] reqSync, reqFilt;
  logic               timeoutHit, holdActive;
  logic [CntW-1:0]    countVal;

  supv_datapath #(
    .TIMEOUT_CYCLES  (TIMEOUT_CYCLES),
    .UV_FILTER_CYCLES(UV_FILTER_CYCLES),
    .MR_FILTER_CYCLES(MR_FILTER_CYCLES),
    .CNT_W           (CntW)
  ) uData (
    .clk       (clk),
    .arstN     (arstN),
    .uvRaw     (uvRaw),
    .manualN   (manualN),
    .strb      (strb),
    .reqSync   (reqSync),
    .reqFilt   (reqFilt),
    .timeoutHit(timeoutHit),
    .countVal  (countVal),
    .holdCause (holdCause)
  );

  supv_control uCtl (
    .clk       (clk),
    .arstN     (arstN),
    .eventAny  (|reqFilt),
    .timeoutHit(timeoutHit),
    .strb      (strb),
    .holdActive(holdActive)
  );

  assign resetN       = ~holdActive;
  assign resetHi      = holdActive;
  assign resetPullLow = holdActive;
endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk #(
  parameter int TIMEOUT_CYCLES   = 50_000_000,
  parameter int UV_FILTER_CYCLES = 2500,
  parameter int MR_FILTER_CYCLES = 25,
  parameter int CNT_W            = 26
) (
  input logic             clk,
  input logic             arstN,
  input logic             resetN,
  input logic             resetHi,
  input logic             resetPullLow,
  input logic [1:0]       holdCause,
  input logic [1:0]       reqSync,
  input logic [1:0]       reqFilt,
  input logic [CNT_W-1:0] countVal
);
  localparam int Sat = TIMEOUT_CYCLES + 8;

  int quietCnt, uvRun, mrRun;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      quietCnt <= 0;
      uvRun    <= 0;
      mrRun    <= 0;
    end else begin
      quietCnt <= (reqFilt != 2'b00) ? 0 : ((quietCnt < Sat) ? quietCnt + 1 : quietCnt);
      uvRun    <= !reqSync[0] ? 0 : ((uvRun < Sat) ? uvRun + 1 : uvRun);
      mrRun    <= !reqSync[1] ? 0 : ((mrRun < Sat) ? mrRun + 1 : mrRun);
    end
  end

  assert_outputs_complement_R8: assert property (@(posedge clk) disable iff (!arstN)
    resetHi != resetN);

  assert_pull_matches_R9: assert property (@(posedge clk) disable iff (!arstN)
    resetPullLow == resetHi);

  assert_event_holds_R2: assert property (@(posedge clk) disable iff (!arstN)
    (reqFilt != 2'b00) |=> (!resetN && countVal == '0));

  assert_full_timeout_R4: assert property (@(posedge clk) disable iff (!arstN)
    $rose(resetN) |-> (quietCnt >= TIMEOUT_CYCLES));

  assert_uv_width_R3: assert property (@(posedge clk) disable iff (!arstN)
    $rose(reqFilt[0]) |-> (uvRun >= UV_FILTER_CYCLES));

  assert_manual_width_R7: assert property (@(posedge clk) disable iff (!arstN)
    $rose(reqFilt[1]) |-> (mrRun >= MR_FILTER_CYCLES));

  assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!arstN)
    resetN |-> (holdCause == 2'b00));
endmodule

bind supv_reset_seq supv_reset_seq_chk #(
  .TIMEOUT_CYCLES  (TIMEOUT_CYCLES),
  .UV_FILTER_CYCLES(UV_FILTER_CYCLES),
  .MR_FILTER_CYCLES(MR_FILTER_CYCLES),
  .CNT_W           (CntW)
) uChk (
  .clk         (clk),
  .arstN       (arstN),
  .resetN      (resetN),
  .resetHi     (resetHi),
  .resetPullLow(resetPullLow),
  .holdCause   (holdCause),
  .reqSync     (reqSync),
  .reqFilt     (reqFilt),
  .countVal    (countVal)
);

// File: tb/supv_reset_seq_test.sv
module supv_reset_seq_test;
  localparam int HZ  = 10_000;   // 100 ms = 1000 cycles, 280 ms = 2800 cycles
  localparam int T   = 1200;
  localparam int UVF = 8;
  localparam int MRF = 4;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic uvRaw = 1'b0;
  logic manualN = 1'b1;
  logic resetN, resetHi, resetPullLow;
  logic [1:0] holdCause;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct {
    int         at;
    bit         rn;
    logic [1:0] cause;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  supv_reset_seq #(
    .CLK_HZ(HZ), .TIMEOUT_CYCLES(T), .UV_FILTER_CYCLES(UVF), .MR_FILTER_CYCLES(MRF)
  ) uut (
    .clk(clk), .arstN(arstN), .uvRaw(uvRaw), .manualN(manualN),
    .resetN(resetN), .resetHi(resetHi), .resetPullLow(resetPullLow),
    .holdCause(holdCause)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endfunction

  function automatic void pushExp(int at, bit rn, logic [1:0] cause, string tag);
    expItem_t it;
    int idx;
    it.at = at; it.rn = rn; it.cause = cause; it.tag = tag;
    idx = expQ.size();
    for (int i = 0; i < expQ.size(); i++) begin
      if (expQ[i].at > at) begin
        idx = i;
        break;
      end
    end
    expQ.insert(idx, it);
  endfunction

  function automatic void compareOutputs(bit rn, logic [1:0] cause, string tag);
    check(resetN == rn, tag, "resetN", int'(resetN), int'(rn));
    check(resetHi == !rn, {tag, " R8"}, "resetHi", int'(resetHi), int'(!rn));
    check(resetPullLow == !rn, {tag, " R9"}, "resetPullLow", int'(resetPullLow), int'(!rn));
    check(holdCause == cause, {tag, " R10"}, "holdCause", int'(holdCause), int'(cause));
  endfunction

  // Scoreboard monitor: compares due items on the falling edge.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      if (it.at < cyc) check(1'b0, it.tag, "missed sample cycle", cyc, it.at);
      else compareOutputs(it.rn, it.cause, it.tag);
    end
  end

  task automatic setUv(input bit v, output int at);
    @(negedge clk);
    uvRaw = v;
    at = cyc;
  endtask

  task automatic setMan(input bit v, output int at);
    @(negedge clk);
    manualN = v;
    at = cyc;
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int c0, c1, c2, c3;

    // R1: reset state, then release after the power-on timeout.
    repeat (3) @(negedge clk);
    compareOutputs(1'b0, 2'b01, "R1 in reset");
    @(negedge clk);
    arstN = 1'b1;
    c0 = cyc;
    pushExp(c0 + T - 1, 1'b0, 2'b01, "R1 still held");
    pushExp(c0 + T, 1'b1, 2'b00, "R1 power-on release");
    drain();

    // R3: undervoltage one cycle short of the filter is ignored.
    setUv(1'b1, c0);
    repeat (UVF - 2) @(negedge clk);
    setUv(1'b0, c1);
    pushExp(c0 + UVF + 3, 1'b1, 2'b00, "R3 short dip ignored");
    pushExp(c0 + 40, 1'b1, 2'b00, "R3 short dip ignored later");
    drain();

    // R2 / R4: accepted undervoltage, then the full timeout.
    setUv(1'b1, c0);
    pushExp(c0 + UVF + 2, 1'b1, 2'b00, "R2 before latency");
    pushExp(c0 + UVF + 3, 1'b0, 2'b01, "R2 asserted");
    repeat (49) @(negedge clk);
    setUv(1'b0, c1);
    pushExp(c1 + T + 3, 1'b0, 2'b01, "R4 last held cycle");
    pushExp(c1 + T + 4, 1'b1, 2'b00, "R4 release");
    drain();

    // R7: manual glitch one cycle short of the filter.
    setMan(1'b0, c0);
    repeat (MRF - 2) @(negedge clk);
    setMan(1'b1, c1);
    pushExp(c0 + MRF + 3, 1'b1, 2'b00, "R7 glitch rejected");
    pushExp(c0 + 30, 1'b1, 2'b00, "R7 glitch rejected later");
    drain();

    // R6: manual pulse of exactly the filter length is accepted.
    setMan(1'b0, c0);
    pushExp(c0 + MRF + 2, 1'b1, 2'b00, "R6 before latency");
    pushExp(c0 + MRF + 3, 1'b0, 2'b10, "R6 minimum pulse asserted");
    repeat (MRF - 1) @(negedge clk);
    setMan(1'b1, c1);
    pushExp(c1 + T + 3, 1'b0, 2'b10, "R4 manual last held cycle");
    pushExp(c1 + T + 4, 1'b1, 2'b00, "R4 manual release");
    drain();

    // R6: long manual press holds reset the whole time.
    setMan(1'b0, c0);
    pushExp(c0 + 35, 1'b0, 2'b10, "R6 held while low");
    repeat (39) @(negedge clk);
    setMan(1'b1, c1);
    pushExp(c1 + 2, 1'b0, 2'b10, "R6 held through release");
    pushExp(c1 + T + 4, 1'b1, 2'b00, "R6 release after timeout");
    drain();

    // R5 / R10: manual press in the middle of an undervoltage timeout.
    setUv(1'b1, c0);
    repeat (19) @(negedge clk);
    setUv(1'b0, c1);
    repeat (599) @(negedge clk);
    setMan(1'b0, c2);
    pushExp(c2 + MRF + 3, 1'b0, 2'b11, "R10 both causes");
    pushExp(c1 + T + 4, 1'b0, 2'b11, "R5 no early release");
    repeat (9) @(negedge clk);
    setMan(1'b1, c3);
    pushExp(c3 + T + 3, 1'b0, 2'b11, "R5 last held cycle");
    pushExp(c3 + T + 4, 1'b1, 2'b00, "R5 restarted release");
    drain();

    // R3: a short dip during the timeout does not restart it.
    setUv(1'b1, c0);
    repeat (19) @(negedge clk);
    setUv(1'b0, c1);
    repeat (299) @(negedge clk);
    setUv(1'b1, c2);
    repeat (UVF - 2) @(negedge clk);
    setUv(1'b0, c3);
    pushExp(c1 + T + 3, 1'b0, 2'b01, "R3 dip mid-timeout held");
    pushExp(c1 + T + 4, 1'b1, 2'b00, "R3 dip mid-timeout no restart");
    drain();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule